// File: doc/BRIEF.md
# Three-Phase Dead-Time PWM Timer

This block produces three complementary pairs of gate signals for a motor inverter. A 10-bit carrier counter sweeps up from zero to a programmable limit and back down again. Each phase compares the carrier with its own threshold, which gives a centre-aligned pulse. That pulse feeds a high-side pin and a low-side pin. An 8-bit dead-time counter in each phase keeps both pins of a pair inactive for a set number of cycles around every switch, so the two transistors of a leg never conduct together.

Software writes new limit and threshold values into shadow inputs at any time. The timer copies them into its working registers only when the carrier is at its bottom point, and it raises a one-cycle carrier pulse at that point. The same clock times both the carrier and the dead time. A fault input with a selectable sensitive edge releases all six pins to high impedance. The counters keep running while it is latched, and the latch clears only when the timer is switched off. The active polarity of the pins can be selected.

Top module: `inv_pwm_timer`

## Requirements
- R1: When enabled, the carrier counts 0,1,…,L,L-1,…,1 and then repeats, so one carrier period is 2·L clock cycles for a limit L of at least 2. `carrier_irq` is high for one cycle once per period.
- R2: For a phase threshold C with 0 < C and C + floor(D/2) < L, the phase's raw drive is active on the cycles where the carrier is below C. That is 2·C−1 cycles per period. The high-side pin (pin 2k for phase k) is active for 2·C−1−(D+1) cycles of each period, and the low-side pin (pin 2k+1) is active for 2·L−(2·C−1)−(D+1) cycles.
- R3: After either pin of a pair goes inactive, both pins of that pair stay inactive for D+1 cycles, where D is `dt_val`. Both pins of a pair are never active in the same cycle.
- R4: A threshold of 0 holds the high-side pin inactive and the low-side pin active for the whole period.
- R5: A threshold with C + floor(D/2) ≥ L holds the high-side pin active for the whole period. A threshold one below that bound still produces a pulse.
- R6: With `act_high`=1 an active pin drives 1. With `act_high`=0 an active pin drives 0.
- R7: While `run_en`=0, `pin_oe` is all zero, the carrier is held at 0 and `carrier_irq` stays low. In the first cycle after enabling, every pin is inactive.
- R8: With `stop_edge`=1 a rising edge on `stop_in` (`stop_edge`=0: a falling edge) sets all `pin_oe` bits to 0 within 4 cycles. The edge of the other polarity has no effect. The condition persists until `run_en` returns to 0, and the carrier keeps its period meanwhile.
- R9: `lim_buf` and `cmp_buf` take effect only at the carrier bottom. A limit written just after a carrier pulse leaves the current period at its old length, and the next period uses the new length.
- R10: `carrier_irq` is high in the cycle right after the carrier was at 0 and low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one carrier and dead-time step per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Timer enable; 0 clears counters and floats pins |
| act_high | input | 1 | 1: active pin level is high; 0: low |
| lim_buf | input | 10 | Shadow carrier limit L |
| cmp_buf | input | 30 | Shadow thresholds, phase k in bits [10k+9:10k] |
| dt_val | input | 8 | Dead-time setting D, gap is D+1 cycles |
| stop_in | input | 1 | Asynchronous fault input |
| stop_edge | input | 1 | Fault sensitive edge: 1 rising, 0 falling |
| pin_o | output | 6 | Gate levels; 2k high side, 2k+1 low side of phase k |
| pin_oe | output | 6 | Output enables; 0 means high impedance |
| carrier_irq | output | 1 | One-cycle pulse after each carrier bottom |

## Verification
The hardest case to reach from the ports is a shadow value arriving in the middle of a running period. The bench waits for the carrier pulse, writes a new limit one cycle later, and then times the next two pulse intervals. The first interval must keep the old length and the second must take the new one. The fault latch is another hard case: while it is held, the pins float but the carrier must keep its period. The bench fires the fault edge during steady operation and times the pulse interval after the pins have gone to high impedance. It also drives the edge of the wrong polarity first and checks that the pins do not float.

// File: rtl/inv_pwm_pkg.sv
package inv_pwm_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/inv_pwm_carrier.sv
module inv_pwm_carrier
    import inv_pwm_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int PHASES = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_en,
    input  logic [CNT_W-1:0]          lim_buf,
    input  logic [PHASES*CNT_W-1:0]   cmp_buf,
    output logic [CNT_W-1:0]          cnt_o,
    output logic [CNT_W-1:0]          lim_o,
    output logic [PHASES*CNT_W-1:0]   cmp_o,
    output logic                      irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0]        cnt;
        dir_e                    dir;
        logic [CNT_W-1:0]        lim;
        logic [PHASES*CNT_W-1:0] cmp;
        logic                    irq;
    } car_t;

    car_t st_d, st_q;
    logic             bottom;
    logic [CNT_W-1:0] eff_lim;

    always_comb begin
        st_d    = st_q;
        bottom  = (st_q.cnt == '0);
        eff_lim = bottom ? lim_buf : st_q.lim;
        if (bottom) begin
            st_d.lim = lim_buf;
            st_d.cmp = cmp_buf;
        end
        st_d.irq = run_en & bottom;
        if (!run_en) begin
            st_d.cnt = '0;
            st_d.dir = DIR_UP;
        end else if (st_q.dir == DIR_UP) begin
            if (st_q.cnt >= eff_lim) begin
                st_d.dir = DIR_DOWN;
                st_d.cnt = bottom ? '0 : st_q.cnt - 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            if (bottom) begin
                st_d.dir = DIR_UP;
                st_d.cnt = (eff_lim == '0) ? '0 : CNT_W'(1);
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign lim_o = st_q.lim;
    assign cmp_o = st_q.cmp;
    assign irq_o = st_q.irq;

    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim);
    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (st_q.cnt == '0) && !st_q.irq);
    p_load_bottom_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |=> $stable(st_q.lim));
endmodule

// File: rtl/inv_pwm_phase.sv
module inv_pwm_phase #(
    parameter int CNT_W = 10,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] lim,
    input  logic [CNT_W-1:0] cmp,
    input  logic [DT_W-1:0]  dt_val,
    output logic             pos_act,
    output logic             neg_act
);
    localparam int SW = ((CNT_W > DT_W) ? CNT_W : DT_W) + 1;

    typedef struct packed {
        logic            raw;
        logic            busy;
        logic [DT_W-1:0] dtc;
    } ph_t;

    ph_t           st_d, st_q;
    logic [SW-1:0] reach;
    logic          want;

    always_comb begin
        st_d  = st_q;
        reach = SW'(cmp) + SW'(dt_val >> 1);
        if (cmp == '0)              want = 1'b0;
        else if (reach >= SW'(lim)) want = 1'b1;
        else                        want = (cnt < cmp);
        if (!run_en) begin
            st_d.raw  = 1'b0;
            st_d.busy = 1'b1;
            st_d.dtc  = dt_val;
        end else begin
            st_d.raw = want;
            if (want != st_q.raw) begin
                st_d.busy = 1'b1;
                st_d.dtc  = dt_val;
            end else if (st_q.busy) begin
                if (st_q.dtc == '0) st_d.busy = 1'b0;
                else                st_d.dtc  = st_q.dtc - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{raw: 1'b0, busy: 1'b1, dtc: '0};
        else        st_q <= st_d;
    end

    assign pos_act =  st_q.raw & ~st_q.busy;
    assign neg_act = ~st_q.raw & ~st_q.busy;

    p_gap_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(neg_act) |-> !pos_act);
    p_gap_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pos_act) |-> !neg_act);
    p_zero_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cmp == '0) |=> !pos_act);
endmodule

// File: rtl/inv_pwm_guard.sv
module inv_pwm_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic stop_in,
    input  logic stop_edge,
    output logic shut_o
);
    typedef struct packed {
        logic [2:0] sync;
        logic       shut;
    } gd_t;

    gd_t  st_d, st_q;
    logic hit;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], stop_in};
        hit = stop_edge ? (st_q.sync[1] & ~st_q.sync[2])
                        : (~st_q.sync[1] & st_q.sync[2]);
        st_d.shut = run_en & (st_q.shut | hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shut_o = st_q.shut;

    p_shut_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.shut && run_en) |=> st_q.shut);
endmodule

// File: rtl/inv_pwm_timer.sv
module inv_pwm_timer #(
    parameter int CNT_W  = 10,
    parameter int DT_W   = 8,
    parameter int PHASES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_en,
    input  logic                    act_high,
    input  logic [CNT_W-1:0]        lim_buf,
    input  logic [PHASES*CNT_W-1:0] cmp_buf,
    input  logic [DT_W-1:0]         dt_val,
    input  logic                    stop_in,
    input  logic                    stop_edge,
    output logic [2*PHASES-1:0]     pin_o,
    output logic [2*PHASES-1:0]     pin_oe,
    output logic                    carrier_irq
);
    localparam int PINS = 2 * PHASES;

    logic [CNT_W-1:0]        cnt_w;
    logic [CNT_W-1:0]        lim_w;
    logic [PHASES*CNT_W-1:0] cmp_w;
    logic [PINS-1:0]         act_w;
    logic                    shut_w;

    inv_pwm_carrier #(.CNT_W(CNT_W), .PHASES(PHASES)) u_carrier (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .lim_buf(lim_buf), .cmp_buf(cmp_buf),
        .cnt_o(cnt_w), .lim_o(lim_w), .cmp_o(cmp_w), .irq_o(carrier_irq)
    );

    for (genvar k = 0; k < PHASES; k++) begin : g_phase
        inv_pwm_phase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_phase (
            .clk(clk), .rst_n(rst_n), .run_en(run_en),
            .cnt(cnt_w), .lim(lim_w), .cmp(cmp_w[k*CNT_W +: CNT_W]),
            .dt_val(dt_val),
            .pos_act(act_w[2*k]), .neg_act(act_w[2*k+1])
        );
    end

    inv_pwm_guard u_guard (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .stop_in(stop_in), .stop_edge(stop_edge), .shut_o(shut_w)
    );

    assign pin_o  = act_high ? act_w : ~act_w;
    assign pin_oe = {PINS{run_en & ~shut_w}};

    p_irq_bottom_r10: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_irq |-> $past(cnt_w == '0));
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_irq |=> !carrier_irq);
endmodule

// File: tb/inv_pwm_timer_test.sv
module inv_pwm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        act_high = 1'b1;
    logic [9:0]  lim_buf = '0;
    logic [29:0] cmp_buf = '0;
    logic [7:0]  dt_val = '0;
    logic        stop_in = 1'b0;
    logic        stop_edge = 1'b1;
    logic [5:0]  pin_o, pin_oe;
    logic        carrier_irq;

    int checks = 0;
    int fails  = 0;
    int pos_n[3];
    int neg_n[3];
    int ovl_n;
    bit done = 1'b0;

    localparam int NV = 6;
    // lim, base threshold, dead time
    localparam int VEC[NV][3] = '{
        '{20,  8, 2}, '{20,  5, 0}, '{32, 12, 5},
        '{16,  3, 1}, '{40, 30, 7}, '{12,  6, 3}
    };

    always #10 clk = ~clk;

    inv_pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .act_high(act_high),
        .lim_buf(lim_buf), .cmp_buf(cmp_buf), .dt_val(dt_val),
        .stop_in(stop_in), .stop_edge(stop_edge),
        .pin_o(pin_o), .pin_oe(pin_oe), .carrier_irq(carrier_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int l, input int c0, input int c1, input int c2, input int d);
        lim_buf = 10'(l);
        cmp_buf = {10'(c2), 10'(c1), 10'(c0)};
        dt_val  = 8'(d);
    endtask

    task automatic restart();
        run_en = 1'b0;
        tick(2);
        run_en = 1'b1;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!carrier_irq && n < 5000);
    endtask

    task automatic measure(input int n);
        ovl_n = 0;
        for (int k = 0; k < 3; k++) begin
            pos_n[k] = 0;
            neg_n[k] = 0;
        end
        repeat (n) begin
            @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                if (pin_o[2*k] == act_high)   pos_n[k]++;
                if (pin_o[2*k+1] == act_high) neg_n[k]++;
                if (pin_o[2*k] == act_high && pin_o[2*k+1] == act_high) ovl_n++;
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n, l, c, d, ep, en;
        tick(2);
        chk(pin_oe == 6'b0, "R7 reset oe", int'(pin_oe), 0);
        chk(carrier_irq == 1'b0, "R7 reset irq", int'(carrier_irq), 0);
        rst_n = 1'b1;
        tick(3);
        chk(pin_oe == 6'b0 && !carrier_irq, "R7 idle oe", int'(pin_oe), 0);

        // vector table: R1 period, R2 widths, R3 no overlap
        for (int v = 0; v < NV; v++) begin
            l = VEC[v][0]; c = VEC[v][1]; d = VEC[v][2];
            cfg(l, c, c + 1, c + 2, d);
            restart();
            wait_irq(n);
            wait_irq(n);
            wait_irq(n);
            chk(n == 2 * l, "R1 period", n, 2 * l);
            measure(2 * l);
            for (int k = 0; k < 3; k++) begin
                ep = 2 * (c + k) - 1 - (d + 1);
                en = 2 * l - (2 * (c + k) - 1) - (d + 1);
                chk(pos_n[k] == ep, "R2 high side width", pos_n[k], ep);
                chk(neg_n[k] == en, "R2 low side width R3 gap", neg_n[k], en);
            end
            chk(ovl_n == 0, "R3 overlap", ovl_n, 0);
            chk(pin_oe == 6'h3f, "R8 oe running", int'(pin_oe), 63);
        end

        // R4 zero threshold
        cfg(20, 0, 0, 0, 2);
        restart();
        wait_irq(n); wait_irq(n); wait_irq(n);
        measure(40);
        chk(pos_n[0] == 0, "R4 high side off", pos_n[0], 0);
        chk(neg_n[0] == 40, "R4 low side full", neg_n[0], 40);

        // R5 clamp and just below
        cfg(20, 17, 16, 0, 6);
        restart();
        wait_irq(n); wait_irq(n); wait_irq(n);
        measure(40);
        chk(pos_n[0] == 40, "R5 clamp full", pos_n[0], 40);
        chk(pos_n[1] == 24, "R5 below bound", pos_n[1], 24);
        chk(neg_n[1] == 2, "R5 below bound low", neg_n[1], 2);

        // R6 active low
        act_high = 1'b0;
        cfg(20, 8, 8, 8, 2);
        restart();
        wait_irq(n); wait_irq(n); wait_irq(n);
        measure(40);
        chk(pos_n[0] == 12, "R6 active low width", pos_n[0], 12);
        act_high = 1'b1;

        // R7 enable gap
        run_en = 1'b0;
        tick(2);
        run_en = 1'b1;
        tick(1);
        chk(pin_o == 6'b0, "R7 inactive after enable", int'(pin_o), 0);
        run_en = 1'b0;
        tick(1);
        chk(pin_oe == 6'b0, "R7 disable floats", int'(pin_oe), 0);
        n = 0;
        repeat (50) begin
            @(negedge clk);
            if (carrier_irq) n++;
        end
        chk(n == 0, "R7 no pulse while off", n, 0);

        // R9 buffered limit
        cfg(20, 5, 5, 5, 1);
        restart();
        wait_irq(n); wait_irq(n);
        tick(1);
        lim_buf = 10'd30;
        wait_irq(n);
        chk(n == 39, "R9 old period kept", n, 39);
        wait_irq(n);
        chk(n == 60, "R9 new period", n, 60);
        tick(1);
        chk(!carrier_irq, "R10 pulse width", int'(carrier_irq), 0);

        // R8 rising-edge shutdown
        cfg(20, 8, 8, 8, 2);
        stop_edge = 1'b1;
        restart();
        wait_irq(n); wait_irq(n);
        stop_in = 1'b1;
        tick(4);
        chk(pin_oe == 6'b0, "R8 rising shut", int'(pin_oe), 0);
        wait_irq(n);
        wait_irq(n);
        chk(n == 40, "R8 carrier runs", n, 40);
        stop_in = 1'b0;
        tick(5);
        chk(pin_oe == 6'b0, "R8 latched", int'(pin_oe), 0);

        // R8 falling-edge mode ignores rising
        stop_edge = 1'b0;
        restart();
        tick(5);
        stop_in = 1'b1;
        tick(6);
        chk(pin_oe == 6'h3f, "R8 wrong edge ignored", int'(pin_oe), 63);
        stop_in = 1'b0;
        tick(4);
        chk(pin_oe == 6'b0, "R8 falling shut", int'(pin_oe), 0);
        run_en = 1'b0;
        tick(2);
        run_en = 1'b1;
        tick(2);
        chk(pin_oe == 6'h3f, "R8 cleared by disable", int'(pin_oe), 63);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule